// File: doc/BRIEF.md
# Processor Clock Prescaler with Low-Supply Throttleback

This block produces the enable that paces the processor. It counts system clock cycles and raises a one-cycle enable once every N cycles. A 3-bit speed code held in a small configuration register selects N. The mapping from code to ratio is not monotonic: four codes give the fast ratios /8, /4, /2 and /1, and the other four give the slow ratios /16, /32, /128 and /256. When the code changes, the new ratio is applied only after the current enable period ends, so no shortened period ever appears at the output. The enable has no consumer other than the processor.

A supply-low comparator output enters the block asynchronously. Two flops synchronize it, and the block acts on the rising edge of the synchronized level. If throttleback is enabled, that edge forces the speed code to the safe /8 setting. If the interrupt mask is set, the same edge also raises a one-cycle low-voltage interrupt request. Hardware never restores the previous speed. Software chooses when to write a faster code back, and that write takes effect normally.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: After reset, the speed code reads 000, no interrupt is pending, and the first enable is high in the eighth clock cycle after reset release, counting the cycle in which reset is released.
- R2: The speed code selects the divide ratio as follows: 000 gives /8, 001 gives /4, 010 gives /2, 011 gives /1, 100 gives /16, 101 gives /32, 110 gives /128 and 111 gives /256.
- R3: Under a steady code with ratio N, the enable is high for one cycle in every N cycles. At /1 it is high in every cycle.
- R4: A new speed code takes effect only at the end of the period in progress. That period completes at its old length.
- R5: The supply-low input passes through two synchronizing flops. The block reacts only to a rising edge of the synchronized level, and its outputs change in the third cycle after the input rises.
- R6: When throttleback is enabled, a supply-low rising edge sets the speed code to 000. This takes priority over a register write in the same cycle.
- R7: When throttleback is disabled, a supply-low event leaves the speed code unchanged.
- R8: A supply-low rising edge raises a one-cycle interrupt request only while the mask bit is 1. With the mask at 0, no request is raised.
- R9: After a throttleback, the speed code stays at 000 even once the supply recovers. A later software write of a faster code takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_speed | input | 3 | Speed code to write |
| cfg_throttle_en | input | 1 | Throttleback enable to write |
| cfg_irq_mask | input | 1 | Low-voltage interrupt mask to write (1 = enabled) |
| supply_low_async | input | 1 | Asynchronous supply-below-trip indication |
| cpu_clk_en | output | 1 | One-cycle processor clock enable |
| lv_irq | output | 1 | One-cycle low-voltage interrupt request |
| speed_code | output | 3 | Current speed code |

## Verification
The assertions assume that the supply-low indication holds each level for at least a few cycles, so that the two-flop synchronizer sees clean edges. They also assume that configuration writes are single-cycle strobes with stable data. The stimulus changes the supply-low input and the write strobe only at falling clock edges. It holds every supply-low level for at least three cycles. It places a write in the same cycle as a forced throttleback only on purpose, to exercise the priority rule.

// File: rtl/cpu_clk_prescaler_pkg.sv
package cpu_clk_prescaler_pkg;
  localparam int SPEED_W   = 3;
  localparam int MAX_SHIFT = 8;
  localparam int CNT_W     = MAX_SHIFT;
  localparam logic [SPEED_W-1:0] RESET_CODE = 3'b000;
  localparam logic [SPEED_W-1:0] SAFE_CODE  = 3'b000;

  // log2 of the divide ratio selected by a speed code (order is behaviour)
  function automatic logic [3:0] code_shift(input logic [SPEED_W-1:0] code);
    logic [3:0] s;
    case (code)
      3'b000:  s = 4'd3;
      3'b001:  s = 4'd2;
      3'b010:  s = 4'd1;
      3'b011:  s = 4'd0;
      3'b100:  s = 4'd4;
      3'b101:  s = 4'd5;
      3'b110:  s = 4'd7;
      default: s = 4'd8;
    endcase
    return s;
  endfunction

  // terminal count (ratio - 1) for a speed code
  function automatic logic [CNT_W-1:0] code_last(input logic [SPEED_W-1:0] code);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << code_shift(code);
    return CNT_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = async_in;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/speed_ctrl.sv
module speed_ctrl
  import cpu_clk_prescaler_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SPEED_W-1:0] cfg_speed,
  input  logic               cfg_throttle_en,
  input  logic               cfg_irq_mask,
  input  logic               low_sync,
  output logic [SPEED_W-1:0] speed_code,
  output logic               lv_irq,
  output logic               low_rise,
  output logic               throttle_en,
  output logic               irq_mask
);
  logic [SPEED_W-1:0] speed_q, speed_d;
  logic               thr_q, thr_d;
  logic               mask_q, mask_d;
  logic               prev_q;
  logic               irq_q, irq_d;

  always_comb begin
    low_rise = low_sync & ~prev_q;
    speed_d  = speed_q;
    thr_d    = thr_q;
    mask_d   = mask_q;
    if (cfg_we) begin
      speed_d = cfg_speed;
      thr_d   = cfg_throttle_en;
      mask_d  = cfg_irq_mask;
    end
    if (low_rise && thr_q) speed_d = SAFE_CODE;  // hardware override wins
    irq_d = low_rise & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= RESET_CODE;
      thr_q   <= 1'b0;
      mask_q  <= 1'b0;
      prev_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      speed_q <= speed_d;
      thr_q   <= thr_d;
      mask_q  <= mask_d;
      prev_q  <= low_sync;
      irq_q   <= irq_d;
    end
  end

  assign speed_code  = speed_q;
  assign lv_irq      = irq_q;
  assign throttle_en = thr_q;
  assign irq_mask    = mask_q;
endmodule

// File: rtl/prescale_counter.sv
module prescale_counter
  import cpu_clk_prescaler_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SPEED_W-1:0] speed_code,
  output logic               tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             wrap;

  always_comb begin
    wrap   = (cnt_q == last_q);
    cnt_d  = cnt_q + 1'b1;
    last_d = last_q;
    if (wrap) begin
      cnt_d  = '0;
      last_d = code_last(speed_code);  // ratio changes only at period end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= code_last(RESET_CODE);
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign tick = wrap;
endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler
  import cpu_clk_prescaler_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_speed,
  input  logic         cfg_throttle_en,
  input  logic         cfg_irq_mask,
  input  logic         supply_low_async,
  output logic         cpu_clk_en,
  output logic         lv_irq,
  output logic [2:0]   speed_code
);
  logic low_sync;
  logic low_rise;
  logic throttle_en;
  logic irq_mask;

  lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (supply_low_async),
    .sync_out (low_sync)
  );

  speed_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_we          (cfg_we),
    .cfg_speed       (cfg_speed),
    .cfg_throttle_en (cfg_throttle_en),
    .cfg_irq_mask    (cfg_irq_mask),
    .low_sync        (low_sync),
    .speed_code      (speed_code),
    .lv_irq          (lv_irq),
    .low_rise        (low_rise),
    .throttle_en     (throttle_en),
    .irq_mask        (irq_mask)
  );

  prescale_counter u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .speed_code (speed_code),
    .tick       (cpu_clk_en)
  );
endmodule

// File: rtl/cpu_clk_prescaler_chk.sv
module cpu_clk_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cpu_clk_en,
  input logic       lv_irq,
  input logic [2:0] speed_code,
  input logic       low_rise,
  input logic       throttle_en,
  input logic       irq_mask
);
  logic [8:0] gap_q;
  logic [9:0] gap_len;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (cpu_clk_en)          gap_q <= '0;
      else if (gap_q != 9'h1FF) gap_q <= gap_q + 1'b1;
    end
  end

  assign gap_len = {1'b0, gap_q} + 10'd1;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (speed_code == 3'b000 && !lv_irq));

  // R2 / R3 / R4: every period is one of the legal ratios, never a runt
  assert_period_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> ($countones(gap_len) == 1 && gap_len != 10'd64 && gap_len <= 10'd256));

  assert_throttle_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_rise && throttle_en) |=> (speed_code == 3'b000));

  // R7 / R9: without a write or a forced throttleback the code holds
  assert_code_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !(low_rise && throttle_en)) |=> $stable(speed_code));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lv_irq |-> $past(low_rise && irq_mask));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lv_irq |=> !lv_irq);
endmodule

bind cpu_clk_prescaler cpu_clk_prescaler_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cpu_clk_en  (cpu_clk_en),
  .lv_irq      (lv_irq),
  .speed_code  (speed_code),
  .low_rise    (low_rise),
  .throttle_en (throttle_en),
  .irq_mask    (irq_mask)
);

// File: tb/cpu_clk_prescaler_test.sv
`timescale 1ns/1ps
module cpu_clk_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_speed;
  logic       cfg_throttle_en;
  logic       cfg_irq_mask;
  logic       supply_low_async;
  logic       cpu_clk_en;
  logic       lv_irq;
  logic [2:0] speed_code;

  int checks = 0;
  int failures = 0;
  int exp_ratio [8] = '{8, 4, 2, 1, 16, 32, 128, 256};

  always #2.5 clk = ~clk;

  cpu_clk_prescaler uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .cfg_speed        (cfg_speed),
    .cfg_throttle_en  (cfg_throttle_en),
    .cfg_irq_mask     (cfg_irq_mask),
    .supply_low_async (supply_low_async),
    .cpu_clk_en       (cpu_clk_en),
    .lv_irq           (lv_irq),
    .speed_code       (speed_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sp, input logic thr, input logic msk);
    cfg_we = 1'b1; cfg_speed = sp; cfg_throttle_en = thr; cfg_irq_mask = msk;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_here();
    while (!cpu_clk_en) @(negedge clk);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!cpu_clk_en);
  endtask

  task automatic t_reset();
    int g;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_speed = '0; cfg_throttle_en = 1'b0;
    cfg_irq_mask = 1'b0; supply_low_async = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 speed code", speed_code, 0);
    check("R1 irq", lv_irq, 0);
    rst_n = 1'b1;
    g = 1;
    while (!cpu_clk_en) begin @(negedge clk); g++; end
    check("R1 first enable cycle", g, 8);
    gap(g);
    check("R3 reset ratio", g, 8);
  endtask

  task automatic t_all_codes();
    int g;
    for (int c = 0; c < 8; c++) begin
      cfg(3'(c), 1'b0, 1'b0);
      wait_here();
      gap(g);
      check($sformatf("R2 code %0d period", c), g, exp_ratio[c]);
      gap(g);
      check($sformatf("R3 code %0d steady", c), g, exp_ratio[c]);
    end
  endtask

  task automatic t_midperiod_throttle();
    int i;
    int g;
    cfg(3'b111, 1'b1, 1'b1);
    wait_here();
    i = 0;
    do begin
      @(negedge clk); i++;
      if (i == 50) supply_low_async = 1'b1;
      if (i == 52) check("R5 no early reaction", lv_irq, 0);
      if (i == 53) begin
        check("R6 forced code", speed_code, 0);
        check("R8 irq raised", lv_irq, 1);
      end
      if (i == 54) check("R8 irq one cycle", lv_irq, 0);
    end while (!cpu_clk_en);
    check("R4 period in progress completes", i, 256);
    gap(g);
    check("R6 safe ratio after throttle", g, 8);
  endtask

  task automatic t_no_restore();
    int g;
    supply_low_async = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 code not restored", speed_code, 0);
    cfg(3'b011, 1'b1, 1'b1);
    check("R9 software write", speed_code, 3);
    wait_here();
    gap(g);
    check("R9 fast ratio after rewrite", g, 1);
  endtask

  task automatic t_throttle_off();
    cfg(3'b010, 1'b0, 1'b1);
    supply_low_async = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 irq with throttle off", lv_irq, 1);
    check("R7 code unchanged", speed_code, 2);
    supply_low_async = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_masked();
    int seen;
    cfg(3'b100, 1'b1, 1'b0);
    supply_low_async = 1'b1;
    seen = 0;
    repeat (8) begin @(negedge clk); if (lv_irq) seen++; end
    check("R8 masked irq count", seen, 0);
    check("R6 forced while masked", speed_code, 0);
    supply_low_async = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_priority();
    cfg(3'b101, 1'b1, 1'b1);
    supply_low_async = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_speed = 3'b111; cfg_throttle_en = 1'b1; cfg_irq_mask = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R6 override beats write", speed_code, 0);
    check("R5 third-cycle irq", lv_irq, 1);
    supply_low_async = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_all_codes();
    t_midperiod_throttle();
    t_no_restore();
    t_throttle_off();
    t_masked();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule